// File: doc/BRIEF.md
# Serial ADC Control-Port Front End

This block is the digital side of the serial port of an eight-channel, 12-bit sampling converter. A host clocks a control byte in over a four-wire serial link using mode 0 (clock idle low, data sampled on the rising edge). The front end ignores any zeros that come first. It frames the byte from the first one bit, decodes it into a channel selection, polarity, input mode and clock/power mode, and raises track and hold flags at fixed points in the byte. In external clock mode it then sends a 12-bit result back, most significant bit first. A one-period strobe comes just before that result.

There is no analog path. The converted value comes from a parallel test input and is captured when the hold flag rises. The serial inputs are sampled by the block's system clock and must be synchronous to it. Each serial-clock level must last at least two system-clock cycles. Every output that is timed by the serial clock changes on the system-clock edge that first sees the falling serial-clock level.

A new control byte can begin while the trailing result bits are still being clocked out. This gives back-to-back conversions of 15 serial clocks each.

Top module: `adcif_port`

## Requirements
- R1: While chip select is low, serial input bits are taken only on rising serial-clock edges. The serial output, result strobe, track and hold change only after a falling serial-clock edge, or when chip select is raised.
- R2: After chip select falls, zero bits received before the first one bit have no effect. That first one bit is the start bit and the most significant bit of the control byte.
- R3: The control byte is decoded on its 8th rising edge, and `cfg_valid` is then set. Byte bits 6..4 are channel selects S2..S0. Bit 3 = 1 means unipolar and 0 means bipolar. Bit 2 = 1 means single-ended and 0 means differential. Bits 1..0 give the mode on `pd_mode`: 00 full power-down, 01 fast power-down, 10 internal clock, 11 external clock.
- R4: In single-ended mode, `ch_pos` = {S1,S0,S2} and `neg_gnd` = 1. An all-ones byte gives channel 7, single-ended, unipolar, external clock.
- R5: In differential mode, `ch_pos` = {S1,S0,S2}, `ch_neg` = {S1,S0,~S2} (the other member of the pair) and `neg_gnd` = 0.
- R6: Track rises, and hold falls, on the falling edge after the 5th control bit. Hold rises, and track falls, on the falling edge after the 8th control bit. Track and hold are never both high.
- R7: In external clock mode, the result strobe is high from the falling edge after bit 8 to the next falling edge. `conv_data` is captured at the falling edge where the strobe rises.
- R8: The captured result appears on the serial output MSB first, one bit per falling edge, on falls 9 to 20 counted from the start bit. After that the serial output is 0.
- R9: In any mode other than external clock, the result strobe never rises and the serial output stays 0.
- R10: Raising chip select clears the serial output, strobe, track, hold and any partial byte or result within one system-clock cycle. The decoded configuration is kept.
- R11: The start-bit search resumes right after bit 8. A second byte started on serial clock 16 gives its strobe on fall 23 and its result on falls 24 to 35, and the first result is not disturbed.
- R12: After reset, all outputs are 0 and `cfg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| conv_data | input | RES_W | Parallel test value used as the conversion result |
| spi_miso | output | 1 | Serial result data to the host |
| res_strobe | output | 1 | One-period pulse ahead of the result MSB |
| track | output | 1 | Sampler tracking flag |
| hold | output | 1 | Sampler hold flag |
| cfg_valid | output | 1 | A control byte has been decoded since reset |
| ch_pos | output | 3 | Positive-input channel |
| ch_neg | output | 3 | Negative-input channel (differential mode only) |
| neg_gnd | output | 1 | Negative input is ground (single-ended) |
| unipolar | output | 1 | 1 means unipolar, 0 means bipolar |
| pd_mode | output | 2 | Clock/power mode field |

## Verification
The checker watches four things on every cycle:
- the edge discipline: no serial-timed output moves without a falling edge;
- track and hold never both high, and a strobe lasting exactly one falling-to-falling period and only in external clock mode;
- the chip-select abort;
- the pairing rule for a differential decode.

The checks that need known stimulus are left to the bench scenarios:
- bit-exact decode of the channel maps;
- leading-zero skipping;
- capturing `conv_data` at hold rather than later;
- result order;
- the 15-clock back-to-back overlap, where the old result shifts out while the next byte arrives.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        PD_FULL = 2'b00,
        PD_FAST = 2'b01,
        CLK_INT = 2'b10,
        CLK_EXT = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic [2:0] ch_pos;
        logic [2:0] ch_neg;
        logic       neg_gnd;
        logic       unipolar;
        pwr_mode_e  mode;
    } ctrl_cfg_t;

    // f holds the seven control bits that follow the start bit, S2 at the top
    function automatic ctrl_cfg_t decode_ctrl(input logic [CTRL_W-2:0] f);
        ctrl_cfg_t c;
        c.ch_pos   = {f[5], f[4], f[6]};
        c.neg_gnd  = f[2];
        c.ch_neg   = f[2] ? 3'd0 : {f[5], f[4], ~f[6]};
        c.unipolar = f[3];
        c.mode     = pwr_mode_e'(f[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/adcif_rx.sv
// Start-bit search and control-byte shifter, advanced on rising serial edges
module adcif_rx #(
    parameter int CTRL_W   = 8,
    parameter int TRACK_AT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              rise,
    input  logic              bit_in,
    output logic [CTRL_W-2:0] fields,
    output logic              got_track,
    output logic              got_last
);
    localparam int CNT_W = $clog2(CTRL_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-2:0] sh;
        logic              trk_p;
        logic              last_p;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d        = q;
        d.trk_p  = 1'b0;
        d.last_p = 1'b0;
        if (abort) begin
            d.cnt = '0;
        end else if (rise) begin
            if (q.cnt == '0) begin
                if (bit_in) begin
                    d.cnt = CNT_W'(1);
                    d.sh  = '0;
                end
            end else begin
                d.sh = {q.sh[CTRL_W-3:0], bit_in};
                if (q.cnt == CNT_W'(TRACK_AT - 1)) begin
                    d.trk_p = 1'b1;
                end
                if (q.cnt == CNT_W'(CTRL_W - 1)) begin
                    d.last_p = 1'b1;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fields    = q.sh;
    assign got_track = q.trk_p;
    assign got_last  = q.last_p;

endmodule

// File: rtl/adcif_tx.sv
// Track/hold flags, result strobe and result shifter, advanced on falling serial edges
module adcif_tx #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             fall,
    input  logic             trk_req,
    input  logic             hold_req,
    input  logic             ext_mode,
    input  logic [RES_W-1:0] conv_data,
    output logic             ser_out,
    output logic             strobe,
    output logic             track,
    output logic             hold
);
    localparam int LEFT_W = $clog2(RES_W + 1);

    typedef struct packed {
        logic              pend_trk;
        logic              pend_hold;
        logic              pend_conv;
        logic              track;
        logic              hold;
        logic              strobe;
        logic              ser_out;
        logic [RES_W-1:0]  sh;
        logic [LEFT_W-1:0] left;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (trk_req) begin
            d.pend_trk = 1'b1;
        end
        if (hold_req) begin
            d.pend_hold = 1'b1;
            d.pend_conv = ext_mode;
        end
        if (abort) begin
            d = '0;
        end else if (fall) begin
            if (q.pend_trk) begin
                d.track    = 1'b1;
                d.hold     = 1'b0;
                d.pend_trk = 1'b0;
            end
            if (q.pend_hold) begin
                d.track     = 1'b0;
                d.hold      = 1'b1;
                d.pend_hold = 1'b0;
            end
            if (q.pend_conv) begin
                d.strobe    = 1'b1;
                d.ser_out   = 1'b0;
                d.sh        = conv_data;
                d.left      = LEFT_W'(RES_W);
                d.pend_conv = 1'b0;
            end else begin
                d.strobe = 1'b0;
                if (q.left != '0) begin
                    d.ser_out = q.sh[RES_W-1];
                    d.sh      = {q.sh[RES_W-2:0], 1'b0};
                    d.left    = q.left - LEFT_W'(1);
                end else begin
                    d.ser_out = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ser_out = q.ser_out;
    assign strobe  = q.strobe;
    assign track   = q.track;
    assign hold    = q.hold;

endmodule

// File: rtl/adcif_port.sv
module adcif_port
    import adcif_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int TRACK_AT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sck,
    input  logic             spi_mosi,
    input  logic [RES_W-1:0] conv_data,
    output logic             spi_miso,
    output logic             res_strobe,
    output logic             track,
    output logic             hold,
    output logic             cfg_valid,
    output logic [2:0]       ch_pos,
    output logic [2:0]       ch_neg,
    output logic             neg_gnd,
    output logic             unipolar,
    output logic [1:0]       pd_mode
);
    localparam int FIELD_W = CTRL_W - 1;

    typedef struct packed {
        logic      sck;
        logic      cfg_valid;
        ctrl_cfg_t cfg;
    } top_t;

    top_t q, d;

    logic               sck_rise;
    logic               sck_fall;
    logic [FIELD_W-1:0] fields;
    logic               got_track;
    logic               got_last;
    ctrl_cfg_t          new_cfg;
    logic               ext_mode;

    assign sck_rise = spi_sck & ~q.sck & ~spi_cs_n;
    assign sck_fall = ~spi_sck & q.sck & ~spi_cs_n;

    adcif_rx #(
        .CTRL_W   (CTRL_W),
        .TRACK_AT (TRACK_AT)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (spi_cs_n),
        .rise      (sck_rise),
        .bit_in    (spi_mosi),
        .fields    (fields),
        .got_track (got_track),
        .got_last  (got_last)
    );

    assign new_cfg  = decode_ctrl(fields);
    assign ext_mode = (new_cfg.mode == CLK_EXT);

    adcif_tx #(
        .RES_W (RES_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (spi_cs_n),
        .fall      (sck_fall),
        .trk_req   (got_track),
        .hold_req  (got_last),
        .ext_mode  (ext_mode),
        .conv_data (conv_data),
        .ser_out   (spi_miso),
        .strobe    (res_strobe),
        .track     (track),
        .hold      (hold)
    );

    always_comb begin
        d     = q;
        d.sck = spi_sck;
        if (got_last) begin
            d.cfg       = new_cfg;
            d.cfg_valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cfg_valid = q.cfg_valid;
    assign ch_pos    = q.cfg.ch_pos;
    assign ch_neg    = q.cfg.ch_neg;
    assign neg_gnd   = q.cfg.neg_gnd;
    assign unipolar  = q.cfg.unipolar;
    assign pd_mode   = q.cfg.mode;

endmodule

// File: rtl/adcif_port_chk.sv
module adcif_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       fall,
    input logic       spi_miso,
    input logic       res_strobe,
    input logic       track,
    input logic       hold,
    input logic       cfg_valid,
    input logic [2:0] ch_pos,
    input logic [2:0] ch_neg,
    input logic       neg_gnd,
    input logic [1:0] pd_mode
);

    p_out_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !fall) |=> ($stable(spi_miso) && $stable(res_strobe)
                                  && $stable(track) && $stable(hold)));

    p_track_hold_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(track && hold));

    p_strobe_one_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_strobe && fall && !spi_cs_n) |=> !res_strobe);

    p_strobe_ext_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_strobe |-> (cfg_valid && pd_mode == 2'b11));

    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> (!res_strobe && !spi_miso && !track && !hold));

    p_diff_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !neg_gnd) |-> (ch_pos[2:1] == ch_neg[2:1] && ch_pos[0] != ch_neg[0]));

endmodule

bind adcif_port adcif_port_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .fall       (sck_fall),
    .spi_miso   (spi_miso),
    .res_strobe (res_strobe),
    .track      (track),
    .hold       (hold),
    .cfg_valid  (cfg_valid),
    .ch_pos     (ch_pos),
    .ch_neg     (ch_neg),
    .neg_gnd    (neg_gnd),
    .pd_mode    (pd_mode)
);

// File: tb/test_adcif_port.sv
module test_adcif_port;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic [11:0] conv_data = '0;
    logic        spi_miso, res_strobe, track, hold, cfg_valid, neg_gnd, unipolar;
    logic [2:0]  ch_pos, ch_neg;
    logic [1:0]  pd_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adcif_port i_adcif_port (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .conv_data(conv_data), .spi_miso(spi_miso),
        .res_strobe(res_strobe), .track(track), .hold(hold), .cfg_valid(cfg_valid),
        .ch_pos(ch_pos), .ch_neg(ch_neg), .neg_gnd(neg_gnd), .unipolar(unipolar),
        .pd_mode(pd_mode)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [1:0]  lz;
        logic [11:0] conv;
        logic [2:0]  pos;
        logic [2:0]  neg;
        logic        gnd;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'hFF, 2'd0, 12'hA5C, 3'd7, 3'd0, 1'b1},
        '{8'h83, 2'd2, 12'h800, 3'd0, 3'd1, 1'b0},
        '{8'hCB, 2'd1, 12'h001, 3'd1, 3'd0, 1'b0},
        '{8'hB7, 2'd3, 12'hFFF, 3'd6, 3'd0, 1'b1},
        '{8'hDA, 2'd0, 12'h123, 3'd3, 3'd2, 1'b0},
        '{8'hAD, 2'd1, 12'h5A5, 3'd4, 3'd0, 1'b1},
        '{8'hE1, 2'd0, 12'hFFF, 3'd5, 3'd4, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sck_rise(input logic b);
        spi_mosi = b;
        spi_sck  = 1'b1;
        tick(3);
    endtask

    task automatic sck_fall();
        spi_sck = 1'b0;
        tick(3);
    endtask

    task automatic sck_cycle(input logic b);
        sck_rise(b);
        sck_fall();
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R12: reset state
        chk("R12", "miso", spi_miso, 0);
        chk("R12", "strobe", res_strobe, 0);
        chk("R12", "track/hold", {track, hold}, 0);
        chk("R12", "cfg_valid", cfg_valid, 0);
        rst_n = 1'b1;
        tick(2);

        // table walk: R2..R9
        foreach (VECS[i]) begin
            conv_data = VECS[i].conv;
            spi_cs_n  = 1'b0;
            tick(2);
            for (int z = 0; z < int'(VECS[i].lz); z++) begin
                sck_cycle(1'b0);
                chk("R2", "track after leading zero", track, 0);
            end
            for (int k = 1; k <= 8; k++) begin
                sck_cycle(VECS[i].ctrl[8-k]);
                if (k == 5) chk("R6", "track/hold after bit5", {track, hold}, 2'b10);
            end
            chk("R6", "track/hold after bit8", {track, hold}, 2'b01);
            chk("R3", "cfg_valid", cfg_valid, 1);
            chk("R3", "pd_mode", pd_mode, VECS[i].ctrl[1:0]);
            chk("R3", "unipolar", unipolar, VECS[i].ctrl[3]);
            chk("R4", "neg_gnd", neg_gnd, VECS[i].gnd);
            chk("R4", "ch_pos", ch_pos, VECS[i].pos);
            if (!VECS[i].gnd) chk("R5", "ch_neg", ch_neg, VECS[i].neg);
            chk("R7", "strobe at fall 8", res_strobe, VECS[i].ctrl[1:0] == 2'b11);
            chk("R8", "miso at fall 8", spi_miso, 0);
            for (int j = 0; j < 13; j++) begin
                sck_cycle(1'b0);
                chk("R7", "strobe after fall 8", res_strobe, 0);
                if (VECS[i].ctrl[1:0] == 2'b11)
                    chk("R8", "result bit", spi_miso, (j < 12) ? VECS[i].conv[11-j] : 1'b0);
                else
                    chk("R9", "miso idle", spi_miso, 0);
            end
            spi_cs_n = 1'b1;
            tick(2);
        end

        // R10: abort mid-byte, then a clean byte decodes correctly
        spi_cs_n = 1'b0;
        tick(2);
        sck_cycle(1'b1); sck_cycle(1'b0); sck_cycle(1'b1); sck_cycle(1'b1); sck_cycle(1'b0);
        chk("R6", "track after partial bit5", track, 1);
        spi_cs_n = 1'b1;
        tick(2);
        chk("R10", "track cleared", {track, hold}, 0);
        chk("R10", "cfg kept", ch_pos, 3'd5);
        conv_data = 12'hFFF;
        spi_cs_n  = 1'b0;
        tick(2);
        for (int k = 7; k >= 0; k--) sck_cycle(logic'((8'h8F >> k) & 1));
        chk("R10", "pos after abort", ch_pos, 3'd0);
        chk("R10", "mode after abort", pd_mode, 2'b11);
        chk("R10", "gnd after abort", neg_gnd, 1);
        sck_cycle(1'b0); sck_cycle(1'b0); sck_cycle(1'b0);
        chk("R8", "result bit before abort", spi_miso, 1);
        spi_cs_n = 1'b1;
        tick(2);
        chk("R10", "miso cleared", spi_miso, 0);
        spi_cs_n = 1'b0;
        tick(2);
        sck_cycle(1'b0);
        chk("R10", "result discarded", spi_miso, 0);
        spi_cs_n = 1'b1;
        tick(2);

        // R11: back-to-back 15-clock conversions; R1 edge discipline
        conv_data = 12'h9A6;
        spi_cs_n  = 1'b0;
        tick(2);
        for (int k = 1; k <= 36; k++) begin
            logic b;
            logic exp_o;
            b = 1'b0;
            if (k <= 8) b = (8'hFF >> (8 - k)) & 1;
            if (k >= 16 && k <= 23) b = (8'h8F >> (23 - k)) & 1;
            if (k == 9) conv_data = 12'h000;
            if (k == 16) conv_data = 12'h3C5;
            sck_rise(b);
            if (k == 8) chk("R1", "strobe before fall", res_strobe, 0);
            if (k == 20) chk("R1", "miso held through high phase", spi_miso, 12'h9A6 >> 1 & 1);
            sck_fall();
            exp_o = 1'b0;
            if (k >= 9 && k <= 20) exp_o = (12'h9A6 >> (20 - k)) & 1;
            if (k >= 24 && k <= 35) exp_o = (12'h3C5 >> (35 - k)) & 1;
            chk("R11", "miso", spi_miso, exp_o);
            chk("R11", "strobe", res_strobe, (k == 8 || k == 23));
        end
        spi_cs_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule